// File: doc/BRIEF.md
# Overdrive Single-Wire Slave Slot Engine

This block is the bit-level slave side of an open-drain, single-wire bus running at overdrive speed. It works from a system clock that oversamples an already synchronised copy of the line. An internal timer restarts on every falling edge from the master and measures the slot from that edge. From this timer the block tells a bus reset from an ordinary slot. It answers a reset with a presence pulse. In a write slot it samples the line and hands the bit upward. In a read slot it pulls the line low to return a zero.

The layer above sees a bit strobe and a byte strobe for received data, assembled least-significant bit first. For transmission it sees a mode level and a bit level, which the engine takes at the master's falling edge and acknowledges with a one-cycle request strobe. The only output toward the wire is a pull-down enable. All timing is set in microseconds through parameters and scaled by the clock rate.

Top module: `sw_slot_slave`

## Requirements
- R1: After reset, the pull-down enable and all strobes (bus reset, bit valid, byte valid, transmit request) are low and the received byte is zero.
- R2: A low level lasting RST_US (40 µs) is reported as a single-cycle bus-reset strobe, RST_US×CYC_PER_US cycles after the first clock edge that sees the line low.
- R3: After a bus reset, the pull-down enable rises PD_WAIT_US (2 µs) plus one cycle after the line goes high, and stays high for exactly PD_LEN_US (8 µs).
- R4: In a write slot the line is sampled SAMPLE_US (3 µs) after the falling edge, and the bit is reported once when the slot ends. A low seen by 3×CYC_PER_US or fewer edges gives 1, and a longer low gives 0.
- R5: Eight reported write bits form one byte, the first bit in bit 0. The byte strobe follows the eighth bit strobe by one cycle, and the byte output changes only with that strobe.
- R6: A slot that starts while the transmit mode is high gives exactly one transmit-request strobe. If the transmit bit is 0, the pull-down is held from the falling edge for RD_HOLD_US (4 µs). If it is 1, the pull-down is never asserted.
- R7: Read slots report no received bit and do not advance byte assembly.
- R8: A bus reset discards a partly assembled byte.
- R9: A low of 16 µs, the longest write-zero, is never taken as a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CYC_PER_US cycles per microsecond |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised bus line level |
| tx_mode_i | input | 1 | High: coming slots are read slots |
| tx_bit_i | input | 1 | Bit to return in the next read slot |
| pd_en_o | output | 1 | Open-drain pull-down enable |
| bus_rst_o | output | 1 | One-cycle strobe on a detected bus reset |
| rx_bit_vld_o | output | 1 | One-cycle strobe at the end of a write slot |
| rx_bit_o | output | 1 | Value of the last write slot |
| rx_byte_vld_o | output | 1 | One-cycle strobe when a byte completes |
| rx_byte_o | output | BYTE_W | Last assembled byte, first bit in bit 0 |
| tx_req_o | output | 1 | One-cycle strobe when a read-slot bit is taken |

## Verification
Write slots are driven with nominal one-lows (1 µs) and zero-lows (8 µs), and also with lows one cycle on each side of the sample point. These show whether the sample lands exactly at 3 µs rather than anywhere between the two nominal windows. Bus resets are interleaved with half-built bytes and with a 16 µs low, which separates true reset detection from a long write-zero and shows that partial bytes are dropped. Read slots of both values are placed between written bytes, which exposes any read slot that leaks into the received stream or returns the wrong hold length.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOT,
      ST_RSTLO,
      ST_PDWAIT,
      ST_PDDRV
   } slot_st_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sw_slot_timer.sv
module sw_slot_timer #(
   parameter int unsigned CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          run_i,
   output logic [CW-1:0] cnt_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (load_i) begin
         cnt_o <= CW'(1);
      end else if (run_i) begin
         cnt_o <= cnt_o + CW'(1);
      end else begin
         cnt_o <= '0;
      end
   end

endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
   import sw_slot_pkg::*;
#(
   parameter int unsigned CW     = 10,
   parameter int unsigned T_SMP  = 60,
   parameter int unsigned T_HOLD = 80,
   parameter int unsigned T_RST  = 800,
   parameter int unsigned T_PDW  = 40,
   parameter int unsigned T_PDL  = 160
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_i,
   input  logic          tx_mode_i,
   input  logic          tx_bit_i,
   input  logic [CW-1:0] cnt_i,
   output logic          load_o,
   output logic          run_o,
   output logic          pd_en_o,
   output logic          bus_rst_o,
   output logic          bit_vld_o,
   output logic          bit_o,
   output logic          tx_req_o
);

   slot_st_e st;
   logic     smp_q;
   logic     is_rd_q;

   logic at_smp, at_hold, past_hold, at_rst, at_pdw, at_pdl;

   assign at_smp    = (cnt_i == CW'(T_SMP));
   assign at_hold   = (cnt_i == CW'(T_HOLD));
   assign past_hold = (cnt_i >= CW'(T_HOLD));
   assign at_rst    = (cnt_i == CW'(T_RST));
   assign at_pdw    = (cnt_i == CW'(T_PDW));
   assign at_pdl    = (cnt_i == CW'(T_PDL));

   always_comb begin
      load_o = 1'b0;
      run_o  = 1'b0;
      unique case (st)
         ST_IDLE:   load_o = !line_i;
         ST_SLOT:   run_o  = 1'b1;
         ST_RSTLO:  load_o = line_i;
         ST_PDWAIT: begin
            load_o = at_pdw;
            run_o  = 1'b1;
         end
         ST_PDDRV:  run_o  = 1'b1;
         default:   run_o  = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         smp_q     <= 1'b0;
         is_rd_q   <= 1'b0;
         pd_en_o   <= 1'b0;
         bus_rst_o <= 1'b0;
         bit_vld_o <= 1'b0;
         bit_o     <= 1'b0;
         tx_req_o  <= 1'b0;
      end else begin
         bus_rst_o <= 1'b0;
         bit_vld_o <= 1'b0;
         tx_req_o  <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (!line_i) begin
                  st      <= ST_SLOT;
                  is_rd_q <= tx_mode_i;
                  if (tx_mode_i) begin
                     tx_req_o <= 1'b1;
                     pd_en_o  <= !tx_bit_i;
                  end
               end
            end
            ST_SLOT: begin
               if (at_smp) smp_q <= line_i;
               if (at_hold) pd_en_o <= 1'b0;
               if (past_hold && line_i) begin
                  st <= ST_IDLE;
                  if (!is_rd_q) begin
                     bit_vld_o <= 1'b1;
                     bit_o     <= smp_q;
                  end
               end else if (at_rst) begin
                  st        <= ST_RSTLO;
                  bus_rst_o <= 1'b1;
                  pd_en_o   <= 1'b0;
               end
            end
            ST_RSTLO: begin
               if (line_i) st <= ST_PDWAIT;
            end
            ST_PDWAIT: begin
               if (at_pdw) begin
                  st      <= ST_PDDRV;
                  pd_en_o <= 1'b1;
               end
            end
            ST_PDDRV: begin
               if (at_pdl) begin
                  st      <= ST_IDLE;
                  pd_en_o <= 1'b0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sw_slot_bytes.sv
module sw_slot_bytes #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   output logic              byte_vld_o,
   output logic [BYTE_W-1:0] byte_o
);

   localparam int unsigned NW = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sh_q;
   logic [NW-1:0]     n_q;
   logic [BYTE_W-1:0] sh_nxt;

   assign sh_nxt = {bit_i, sh_q[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         n_q        <= '0;
         byte_vld_o <= 1'b0;
         byte_o     <= '0;
      end else begin
         byte_vld_o <= 1'b0;
         if (clr_i) begin
            n_q  <= '0;
            sh_q <= '0;
         end else if (bit_vld_i) begin
            sh_q <= sh_nxt;
            if (n_q == NW'(BYTE_W - 1)) begin
               n_q        <= '0;
               byte_vld_o <= 1'b1;
               byte_o     <= sh_nxt;
            end else begin
               n_q <= n_q + NW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/sw_slot_slave.sv
module sw_slot_slave
   import sw_slot_pkg::*;
#(
   parameter int unsigned CYC_PER_US = 20,
   parameter int unsigned SAMPLE_US  = 3,
   parameter int unsigned RD_HOLD_US = 4,
   parameter int unsigned RST_US     = 40,
   parameter int unsigned PD_WAIT_US = 2,
   parameter int unsigned PD_LEN_US  = 8,
   parameter int unsigned BYTE_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic              tx_mode_i,
   input  logic              tx_bit_i,
   output logic              pd_en_o,
   output logic              bus_rst_o,
   output logic              rx_bit_vld_o,
   output logic              rx_bit_o,
   output logic              rx_byte_vld_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              tx_req_o
);

   localparam int unsigned T_SMP  = SAMPLE_US  * CYC_PER_US;
   localparam int unsigned T_HOLD = RD_HOLD_US * CYC_PER_US;
   localparam int unsigned T_RST  = RST_US     * CYC_PER_US;
   localparam int unsigned T_PDW  = PD_WAIT_US * CYC_PER_US;
   localparam int unsigned T_PDL  = PD_LEN_US  * CYC_PER_US;
   localparam int unsigned T_MAX  = max4(T_HOLD, T_RST, T_PDW, T_PDL);
   localparam int unsigned CW     = $clog2(T_MAX + 2);

   if (CYC_PER_US < 2) begin : g_bad_clk
      $error("CYC_PER_US must be at least 2");
   end
   if (SAMPLE_US < 2 || SAMPLE_US >= 6) begin : g_bad_smp
      $error("SAMPLE_US must fall between the write-one and write-zero windows");
   end
   if (RD_HOLD_US <= SAMPLE_US || RD_HOLD_US > 6) begin : g_bad_hold
      $error("RD_HOLD_US must exceed SAMPLE_US and end before the earliest write-zero release");
   end
   if (RST_US <= 16 || RST_US > 48) begin : g_bad_rst
      $error("RST_US must exceed the longest write-zero and not exceed the shortest reset");
   end
   if (PD_WAIT_US > 7 || PD_WAIT_US + PD_LEN_US < 10) begin : g_bad_pd
      $error("presence pulse must cover the master sample window");
   end
   if (BYTE_W < 2) begin : g_bad_w
      $error("BYTE_W must be at least 2");
   end

   logic          tm_load, tm_run;
   logic [CW-1:0] tm_cnt;

   sw_slot_timer #(.CW(CW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tm_load),
      .run_i  (tm_run),
      .cnt_o  (tm_cnt)
   );

   sw_slot_fsm #(
      .CW     (CW),
      .T_SMP  (T_SMP),
      .T_HOLD (T_HOLD),
      .T_RST  (T_RST),
      .T_PDW  (T_PDW),
      .T_PDL  (T_PDL)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_i),
      .tx_mode_i (tx_mode_i),
      .tx_bit_i  (tx_bit_i),
      .cnt_i     (tm_cnt),
      .load_o    (tm_load),
      .run_o     (tm_run),
      .pd_en_o   (pd_en_o),
      .bus_rst_o (bus_rst_o),
      .bit_vld_o (rx_bit_vld_o),
      .bit_o     (rx_bit_o),
      .tx_req_o  (tx_req_o)
   );

   sw_slot_bytes #(.BYTE_W(BYTE_W)) u_bytes (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (bus_rst_o),
      .bit_vld_i  (rx_bit_vld_o),
      .bit_i      (rx_bit_o),
      .byte_vld_o (rx_byte_vld_o),
      .byte_o     (rx_byte_o)
   );

endmodule

// File: rtl/sw_slot_slave_chk.sv
module sw_slot_slave_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_i,
   input logic              tx_mode_i,
   input logic              tx_bit_i,
   input logic              pd_en_o,
   input logic              bus_rst_o,
   input logic              rx_bit_vld_o,
   input logic              rx_bit_o,
   input logic              rx_byte_vld_o,
   input logic [BYTE_W-1:0] rx_byte_o,
   input logic              tx_req_o
);

   // R2
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_o |=> !bus_rst_o);

   // R2
   rst_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_o |-> !line_i);

   // R3
   rst_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_o |-> !pd_en_o);

   // R4
   bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bit_vld_o |=> !rx_bit_vld_o);

   // R4
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_bit_vld_o |-> $stable(rx_bit_o));

   // R5
   byte_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_byte_vld_o |-> $past(rx_bit_vld_o));

   // R5
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_byte_vld_o |-> $stable(rx_byte_o));

   // R6
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_o |=> !tx_req_o);

   // R6
   req_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_o |-> (pd_en_o == !$past(tx_bit_i)) && $past(tx_mode_i));

   // R7
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bit_vld_o |-> !pd_en_o && !tx_req_o);

endmodule

bind sw_slot_slave sw_slot_slave_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sw_slot_slave_bench.sv
`timescale 1ns/1ps
module sw_slot_slave_bench;

   localparam int C      = 20;
   localparam int T_RST  = 40 * C;
   localparam int T_PDW  = 2 * C;
   localparam int T_PDL  = 8 * C;
   localparam int T_HOLD = 4 * C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_low = 1'b0;
   logic       tx_mode = 1'b0;
   logic       tx_bit = 1'b1;
   logic       line;
   logic       pd_en_o, bus_rst_o, rx_bit_vld_o, rx_bit_o, rx_byte_vld_o, tx_req_o;
   logic [7:0] rx_byte_o;

   int checks = 0;
   int errors = 0;
   int rst_seen = 0;
   bit done = 1'b0;

   bit         exp_q[$];
   logic [7:0] exp_byte_q[$];
   int         nbits = 0;
   logic [7:0] acc = '0;
   bit         e_b;
   logic [7:0] e_y;

   assign line = !(m_low || pd_en_o);

   always #2.5 clk = !clk;

   sw_slot_slave u_sw_slot_slave (
      .clk           (clk),
      .rst_n         (rst_n),
      .line_i        (line),
      .tx_mode_i     (tx_mode),
      .tx_bit_i      (tx_bit),
      .pd_en_o       (pd_en_o),
      .bus_rst_o     (bus_rst_o),
      .rx_bit_vld_o  (rx_bit_vld_o),
      .rx_bit_o      (rx_bit_o),
      .rx_byte_vld_o (rx_byte_vld_o),
      .rx_byte_o     (rx_byte_o),
      .tx_req_o      (tx_req_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_rst_o) rst_seen++;
         if (rx_bit_vld_o) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected received bit", int'(rx_bit_o), -1);
            end else begin
               e_b = exp_q.pop_front();
               chk(rx_bit_o == e_b, "R4 received bit", int'(rx_bit_o), int'(e_b));
            end
         end
         if (rx_byte_vld_o) begin
            if (exp_byte_q.size() == 0) begin
               chk(1'b0, "R8 unexpected byte", int'(rx_byte_o), -1);
            end else begin
               e_y = exp_byte_q.pop_front();
               chk(rx_byte_o == e_y, "R5 received byte", int'(rx_byte_o), int'(e_y));
            end
         end
      end
   end

   task automatic wslot(input bit b, input int low);
      int tot;
      tot = (low + 100 > 240) ? low + 100 : 240;
      exp_q.push_back(b);
      acc[nbits] = b;
      if (nbits == 7) begin
         exp_byte_q.push_back(acc);
         nbits = 0;
      end else begin
         nbits++;
      end
      @(negedge clk);
      m_low = 1'b1;
      repeat (low) @(negedge clk);
      m_low = 1'b0;
      repeat (tot - low) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) wslot(v[i], v[i] ? 20 : 160);
   endtask

   task automatic rslot(input bit b);
      int hi, req, bits;
      logic ln;
      hi = 0; req = 0; bits = 0; ln = 1'bx;
      tx_mode = 1'b1;
      tx_bit  = b;
      @(negedge clk);
      m_low = 1'b1;
      for (int i = 1; i <= 240; i++) begin
         @(negedge clk);
         if (i == 20) m_low = 1'b0;
         if (pd_en_o) hi++;
         if (tx_req_o) req++;
         if (rx_bit_vld_o) bits++;
         if (i == 40) ln = line;
      end
      tx_mode = 1'b0;
      tx_bit  = 1'b1;
      chk(req == 1, "R6 request count", req, 1);
      chk(hi == (b ? 0 : T_HOLD), "R6 hold length", hi, b ? 0 : T_HOLD);
      chk(ln == b, "R6 line at master sample", int'(ln), int'(b));
      chk(bits == 0, "R7 bit strobe in read slot", bits, 0);
   endtask

   task automatic breset();
      int first, rise, ph, base;
      first = -1; rise = -1; ph = 0; base = rst_seen;
      nbits = 0; acc = '0;
      @(negedge clk);
      m_low = 1'b1;
      for (int i = 1; i <= 960; i++) begin
         @(negedge clk);
         if (bus_rst_o && first < 0) first = i;
      end
      m_low = 1'b0;
      for (int i = 1; i <= 960; i++) begin
         @(negedge clk);
         if (pd_en_o) begin
            if (rise < 0) rise = i;
            ph++;
         end
      end
      chk(first == T_RST + 1, "R2 reset strobe cycle", first, T_RST + 1);
      chk(rst_seen - base == 1, "R2 reset strobe count", rst_seen - base, 1);
      chk(rise == T_PDW + 1, "R3 presence start", rise, T_PDW + 1);
      chk(ph == T_PDL, "R3 presence length", ph, T_PDL);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1
      chk(!pd_en_o && !bus_rst_o && !rx_bit_vld_o && !rx_byte_vld_o && !tx_req_o && rx_byte_o == 8'h00,
          "R1 reset state", int'({pd_en_o, bus_rst_o, rx_bit_vld_o, rx_byte_vld_o, tx_req_o}), 0);

      breset();

      // R9: a 16 us low is a write-zero, not a reset
      base = rst_seen;
      wslot(1'b0, 320);
      chk(rst_seen == base, "R9 long low taken as reset", rst_seen - base, 0);

      // R8: the reset drops the pending bit
      breset();
      send_byte(8'hA5);

      // R4 sample-point boundary
      wslot(1'b1, 59);
      wslot(1'b0, 61);
      wslot(1'b1, 20);
      wslot(1'b1, 20);
      wslot(1'b0, 160);
      wslot(1'b0, 160);
      wslot(1'b1, 20);
      wslot(1'b0, 160);

      // R6, R7: read slots between bytes
      rslot(1'b0);
      rslot(1'b1);
      rslot(1'b1);
      rslot(1'b0);
      send_byte(8'h3C);

      // R8: partial byte then reset
      wslot(1'b1, 20);
      wslot(1'b1, 20);
      wslot(1'b1, 20);
      exp_q.delete();
      breset();
      send_byte(8'h81);

      repeat (50) @(negedge clk);
      chk(exp_q.size() == 0, "R4 missing bits", exp_q.size(), 0);
      chk(exp_byte_q.size() == 0, "R5 missing bytes", exp_byte_q.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule